// File: doc/BRIEF.md
# Queued-Duty Pulse Width Modulator

This block produces one pulse-width-modulated output from a prescaled up-counter that compares against an active duty value. Software programs it through a plain register port with byte offsets. Each write to the duty register goes into a small first-in first-out queue; it never goes directly to the comparator. The comparator's active duty value changes only when the counter wraps, and each wrap takes at most one queued value. This holds even when the queue is empty at the moment of the write. A write that lowers the duty therefore cannot land below a counter that has already passed it and leave a whole period high.

The output is high from the start of a period until the counter first reaches or passes the active duty value. After that it stays low until the wrap. The comparison is "greater than or equal" rather than equality, so a missed exact match still ends the pulse.

The register port has no back-pressure. Reads are combinational and writes take effect in one cycle. A duty write that finds the queue full is dropped and recorded in a sticky flag. Software paces its writes with the fill level, the low-water flag and the `fifo_empty` pin. The control and status pins are plain level signals.

Top module: `pwm_sample_queue`

## Requirements
- R1: After reset the following read as zero: control, period, counter, active duty and `pwm_out`. Status reads 0x500: fill level 0, low-water flag set, empty flag set, overflow clear. `fifo_empty` is 1.
- R2: Register byte offsets are control 0x00, status 0x04, duty 0x0C, period 0x10 and counter 0x14; other offsets read 0. Control fields: bit 0 enable, bit 3 soft reset (write 1, reads 0), bits 15:4 prescaler, bit 25 stop-enable, bits 27:26 watermark. Status fields: bits 7:0 fill level, bit 8 low-water, bit 9 overflow, bit 10 empty. A read of the duty offset returns the active duty value.
- R3: `pwm_out` is high while counter < active duty and low otherwise. A duty of 0 gives a constant low output, and a duty above the period value gives a constant high output.
- R4: The counter runs from 0 to the period value inclusive and then wraps to 0. It advances once every prescaler+1 clocks.
- R5: Duty writes are queued, up to four entries. Each wrap moves the oldest entry into the active duty, so entries are applied in write order, one per period. A wrap with an empty queue leaves the active duty unchanged.
- R6: A duty write made mid-period with an empty queue does not change the output in that period. A lower value written while the counter is already above it still lets the current period end its pulse at the old duty.
- R7: A duty write while four entries are queued is dropped and sets the sticky overflow bit. Writing 1 to status bit 9 clears the bit.
- R8: The low-water flag is 1 exactly when the fill level is less than or equal to the watermark field.
- R9: Any write to the period register restarts the counter and prescaler at 0.
- R10: Clearing enable freezes the counter and `pwm_out`. Setting it again resumes counting from the frozen count.
- R11: While `sys_stop` is high the counter freezes unless stop-enable is set.
- R12: Writing the soft reset bit empties the queue and clears the overflow flag, the counter and the prescaler on the next clock. The bit reads back as 0 afterwards.
- R13: `fifo_empty` is high exactly when no duty entry is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| sys_stop | input | 1 | System stop request |
| pwm_out | output | 1 | Modulated output |
| fifo_empty | output | 1 | High when no duty value is queued |

## Verification
The bench builds the block with its default parameters: 16-bit duty and period, a four-entry queue and a 12-bit prescaler. It uses short periods of 10 and 20 counts so that each period's high time can be counted sample by sample. With a four-entry queue, the fill, watermark and overflow boundaries are reached in a handful of writes. A small prescaler value of 2 makes the divided step visible in three clocks. The key scenario lowers the duty from 15 to 5 while the counter sits at 11 with an empty queue. The bench then checks that the old pulse still ends at count 15 and that the next period is exactly 5 counts high.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int PRESC_W = 12;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_DUTY = 8'h0C;
  localparam logic [7:0] OFS_PER  = 8'h10;
  localparam logic [7:0] OFS_CNT  = 8'h14;

  localparam int B_EN       = 0;
  localparam int B_SWRST    = 3;
  localparam int B_PRESC_LO = 4;
  localparam int B_STOPEN   = 25;
  localparam int B_WM_LO    = 26;

  localparam int S_LOW   = 8;
  localparam int S_OVF   = 9;
  localparam int S_EMPTY = 10;

  typedef struct packed {
    logic [1:0]         wm;
    logic               stop_en;
    logic [PRESC_W-1:0] presc;
    logic               en;
  } ctrl_t;
endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
  import pwmq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output ctrl_t             ctrl,
  output logic              swrst,
  output logic [DATA_W-1:0] period,
  output logic              period_wr,
  output logic              duty_wr,
  output logic              ovf_clr
);
  logic hit_ctrl, hit_stat, hit_duty, hit_per;

  assign hit_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = wr_en && (addr == ADDR_W'(OFS_STAT));
  assign hit_duty = wr_en && (addr == ADDR_W'(OFS_DUTY));
  assign hit_per  = wr_en && (addr == ADDR_W'(OFS_PER));

  assign period_wr = hit_per;
  assign duty_wr   = hit_duty;
  assign ovf_clr   = hit_stat && wdata[S_OVF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      swrst  <= 1'b0;
      period <= '0;
    end else begin
      swrst <= hit_ctrl && wdata[B_SWRST];
      if (hit_ctrl) begin
        ctrl.en      <= wdata[B_EN];
        ctrl.presc   <= wdata[B_PRESC_LO +: PRESC_W];
        ctrl.stop_en <= wdata[B_STOPEN];
        ctrl.wm      <= wdata[B_WM_LO +: 2];
      end
      if (hit_per) period <= wdata[DATA_W-1:0];
    end
  end

  AST_SWRST_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (swrst && !(hit_ctrl && wdata[B_SWRST])) |=> !swrst); // R12
endmodule

// File: rtl/pwmq_fifo.sv
module pwmq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  input  logic             ovf_clr,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] fill,
  output logic             empty,
  output logic             full,
  output logic             ovf
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign empty   = (fill == '0);
  assign full    = (fill == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      ovf    <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      fill <= fill + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (push && full)  ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[i] <= '0;
        else if (push_ok && !flush && wr_ptr == PTR_W'(i)) mem[i] <= din;
      end
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH)); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (fill == CNT_W'(DEPTH)) && ovf); // R7
  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty && !flush) |=> fill == $past(fill) - 1'b1); // R5
endmodule

// File: rtl/pwmq_timebase.sv
module pwmq_timebase #(
  parameter int DATA_W  = 16,
  parameter int PRESC_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [PRESC_W-1:0] presc,
  input  logic [DATA_W-1:0]  period,
  output logic [DATA_W-1:0]  cnt,
  output logic               wrap
);
  logic [PRESC_W-1:0] pre;
  logic               tick;

  assign tick = run && (pre >= presc);
  assign wrap = tick && (cnt == period) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (restart) begin
      pre <= '0;
      cnt <= '0;
    end else if (run) begin
      if (tick) begin
        pre <= '0;
        cnt <= (cnt == period) ? '0 : cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !$changed(period)) |-> cnt <= period); // R4
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt)); // R10
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0); // R9
endmodule

// File: rtl/pwm_sample_queue.sv
module pwm_sample_queue
  import pwmq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sys_stop,
  output logic              pwm_out,
  output logic              fifo_empty
);
  ctrl_t             ctrl;
  logic              swrst, period_wr, duty_wr, ovf_clr;
  logic [DATA_W-1:0] period, cnt, duty_act, q_head;
  logic [CNT_W-1:0]  fill;
  logic              q_empty, q_full, ovf, wrap, run;

  pwmq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .ctrl(ctrl), .swrst(swrst), .period(period),
    .period_wr(period_wr), .duty_wr(duty_wr), .ovf_clr(ovf_clr)
  );

  pwmq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(swrst), .push(duty_wr),
    .din(reg_wdata[DATA_W-1:0]), .pop(wrap), .ovf_clr(ovf_clr),
    .dout(q_head), .fill(fill), .empty(q_empty), .full(q_full), .ovf(ovf)
  );

  assign run = ctrl.en && (!sys_stop || ctrl.stop_en);

  pwmq_timebase #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(period_wr || swrst),
    .presc(ctrl.presc), .period(period), .cnt(cnt), .wrap(wrap)
  );

  // The active compare value changes only on a wrap, and only from the queue.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                duty_act <= '0;
    else if (wrap && !q_empty) duty_act <= q_head;
  end

  assign pwm_out    = (cnt < duty_act);
  assign fifo_empty = q_empty;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_W'(OFS_CTRL): begin
        reg_rdata[B_EN]                 = ctrl.en;
        reg_rdata[B_PRESC_LO +: PRESC_W] = ctrl.presc;
        reg_rdata[B_STOPEN]             = ctrl.stop_en;
        reg_rdata[B_WM_LO +: 2]         = ctrl.wm;
      end
      ADDR_W'(OFS_STAT): begin
        reg_rdata[CNT_W-1:0] = fill;
        reg_rdata[S_LOW]     = (32'(fill) <= 32'(ctrl.wm));
        reg_rdata[S_OVF]     = ovf;
        reg_rdata[S_EMPTY]   = q_empty;
      end
      ADDR_W'(OFS_DUTY): reg_rdata[DATA_W-1:0] = duty_act;
      ADDR_W'(OFS_PER):  reg_rdata[DATA_W-1:0] = period;
      ADDR_W'(OFS_CNT):  reg_rdata[DATA_W-1:0] = cnt;
      default:           reg_rdata = '0;
    endcase
  end

  AST_DUTY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_act)); // R5
  AST_EMPTY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && q_empty) |=> $stable(duty_act)); // R5
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !fifo_empty); // R13
endmodule

// File: tb/pwm_sample_queue_test.sv
`timescale 1ns/1ps
module pwm_sample_queue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_stop = 1'b0;
  logic        pwm_out, fifo_empty;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pwm_sample_queue uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_stop(sys_stop),
    .pwm_out(pwm_out), .fifo_empty(fifo_empty)
  );

  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_DUTY = 8'h0C,
                         A_PER = 8'h10, A_CNT = 8'h14;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic wait_cnt(input int v);
    int c;
    for (int i = 0; i < 2000; i++) begin
      rd(A_CNT, c);
      if (c == v) return;
      @(negedge clk);
    end
    chk("poll", c, v);
  endtask

  // Counts high samples over one full period starting at count 0 (prescaler 0).
  task automatic measure(input int per, output int highs);
    highs = 0;
    wait_cnt(0);
    for (int i = 0; i <= per; i++) begin
      #1;
      if (pwm_out) highs++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 32'h500);
    rd(A_CNT, v);  chk("R1 counter", v, 0);
    rd(A_PER, v);  chk("R1 period", v, 0);
    rd(A_DUTY, v); chk("R1 duty", v, 0);
    rd(8'h08, v);  chk("R2 unmapped", v, 0);
    chk("R1 pwm_out", int'(pwm_out), 0);
    chk("R13 empty pin", int'(fifo_empty), 1);
  endtask

  task automatic t_order;
    int h, v;
    wr(A_PER, 9);
    wr(A_DUTY, 3); wr(A_DUTY, 7); wr(A_DUTY, 11);
    rd(A_STAT, v); chk("R5 fill 3", v & 8'hFF, 3);
    chk("R13 not empty", int'(fifo_empty), 0);
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    measure(9, h); chk("R5 first entry", h, 3);
    measure(9, h); chk("R5 second entry", h, 7);
    measure(9, h); chk("R3 duty above period", h, 10);
    measure(9, h); chk("R5 empty keeps duty", h, 10);
    rd(A_DUTY, v); chk("R2 duty readback", v, 11);
    wr(A_DUTY, 0);
    measure(9, h); chk("R3 duty zero", h, 0);
    wr(A_DUTY, 4);
    measure(9, h); chk("R3 duty 4", h, 4);
  endtask

  task automatic t_lower;
    int h, v;
    wr(A_PER, 19);
    wr(A_DUTY, 15);
    measure(19, h); chk("R3 duty 15", h, 15);
    wait_cnt(10);
    wr(A_DUTY, 5);
    rd(A_CNT, v); chk("R6 count at write", v, 12);
    #1; chk("R6 old duty still high", int'(pwm_out), 1);
    rd(A_STAT, v); chk("R5 queued not applied", v & 8'hFF, 1);
    wait_cnt(14); #1; chk("R6 high at 14", int'(pwm_out), 1);
    wait_cnt(15); #1; chk("R6 low at 15", int'(pwm_out), 0);
    measure(19, h); chk("R6 next period 5", h, 5);
    rd(A_STAT, v); chk("R13 empty after pop", v, 32'h500);
  endtask

  task automatic t_restart;
    int v;
    wait_cnt(8);
    wr(A_PER, 19);
    rd(A_CNT, v); chk("R9 restart", v, 0);
  endtask

  task automatic t_presc;
    int v;
    wr(A_CTRL, 32'h21);
    wr(A_PER, 9);
    @(negedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R4 held 3 clocks", v, 0);
    @(negedge clk);
    rd(A_CNT, v); chk("R4 step after 3", v, 1);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R4 second step", v, 2);
    wr(A_CTRL, 32'h1);
    wr(A_PER, 19);
  endtask

  task automatic t_freeze;
    int c0, c1, o0;
    wr(A_DUTY, 10);
    wait_cnt(0);
    wait_cnt(4);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, c0); #1; o0 = int'(pwm_out);
    repeat (10) @(negedge clk);
    rd(A_CNT, c1); chk("R10 count frozen", c1, c0);
    #1; chk("R10 output frozen", int'(pwm_out), o0);
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    rd(A_CNT, c1); chk("R10 resume", c1, (c0 + 1) % 20);
  endtask

  task automatic t_stop;
    int c0, c1;
    @(negedge clk); sys_stop = 1'b1;
    @(negedge clk);
    rd(A_CNT, c0);
    repeat (5) @(negedge clk);
    rd(A_CNT, c1); chk("R11 stop freezes", c1, c0);
    wr(A_CTRL, 32'h0200_0001);
    rd(A_CNT, c0);
    @(negedge clk);
    rd(A_CNT, c1); chk("R11 stop-enable runs", c1, (c0 + 1) % 20);
    sys_stop = 1'b0;
  endtask

  task automatic t_queue_limits;
    int v;
    wr(A_CTRL, 32'h0800_0000);
    wr(A_DUTY, 1); wr(A_DUTY, 2);
    rd(A_STAT, v); chk("R8 low at fill 2 wm 2", v, 32'h102);
    wr(A_DUTY, 3);
    rd(A_STAT, v); chk("R8 not low at fill 3", v, 32'h003);
    wr(A_DUTY, 4); wr(A_DUTY, 5);
    rd(A_STAT, v); chk("R7 drop and overflow", v, 32'h204);
    wr(A_STAT, 32'h200);
    rd(A_STAT, v); chk("R7 overflow cleared", v, 32'h004);
    wr(A_DUTY, 6);
    wr(A_CTRL, 32'h0800_0008);
    @(negedge clk);
    rd(A_STAT, v); chk("R12 flushed", v, 32'h500);
    rd(A_CNT, v);  chk("R12 counter cleared", v, 0);
    rd(A_CTRL, v); chk("R12 bit self-clears", v, 32'h0800_0000);
    chk("R13 empty pin after flush", int'(fifo_empty), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_lower();
    t_restart();
    t_presc();
    t_freeze();
    t_stop();
    t_queue_limits();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule